// File: doc/BRIEF.md
# Flash Command Sequencer with Key Guard

This block sits between a processor bus and an on-chip flash array. Its control register stays closed to software until two fixed key words arrive, one after the other, on the key register. Once the block is open, software can erase one sector or program single bytes. The block drives one-cycle command strobes toward a behavioural flash array. While an operation runs, a busy bit stays high for a number of clock cycles set by a parameter.

The register bus has no back-pressure. Every write is taken in the cycle it is presented, and reads are combinational from the address. The byte-program path has no back-pressure either: a byte written while an operation is running is dropped and recorded as a sequence error, so software polls busy first. Each of the two banks has twelve sectors, and a bank-select bit inside the sector field picks the bank. The block computes the start address and size of the sector being erased and places them on the erase port.

Register offsets (bus_addr): 0 = key, 1 = control, 2 = status.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is locked and idle. Control reads 0x8000_0000 (bit 31 = locked), status reads 0x0000_0008 (bit 3 = locked), and busy is 0.
- R2: The block unlocks only when 0x45670123 is written to the key register and the next key-register write is 0xCDEF89AB. Status bit 3 and control bit 31 then read 0.
- R3: The block enters a lock-out state if either key write carries a wrong value, or if a key write arrives while the block is unlocked. In lock-out, status bit 4 reads 1 and the block stays locked, even after a correct key pair, until reset.
- R4: While the block is locked, control-register writes are ignored. Control fields read back unchanged, and no erase is started.
- R5: An unlocked, idle control write with bit 31 set re-locks the block at once and changes no other field. A fresh key pair is then needed to unlock.
- R6: An erase starts only on an unlocked, idle control write with start (bit 2) and sector-erase (bit 1) set and a sector index (bits 7:4) below 12. Bit 8 selects the bank. er_go pulses one cycle with er_bank, er_index, the size (16 KiB for sectors 0–3, 64 KiB for sector 4, 128 KiB for sectors 5–11) and the base address. The base address is FLASH_BASE + bank·1 MiB + the sum of the sizes of the lower sectors.
- R7: busy stays high for exactly ERASE_CYC cycles after an erase starts and PROG_CYC cycles after a program starts. When the operation completes, start reads 0 again. Sector-erase (bit 1) and program-enable (bit 0) keep their values.
- R8: While the block is unlocked, idle and has program-enable set, each byte write on the memory port pulses pg_go for one cycle with that address and data, and starts a program operation.
- R9: A byte write is ignored if program-enable is clear or if the block is locked. pg_go does not pulse and busy stays 0.
- R10: A start attempt while busy is ignored, whether it is a control write with start set or a byte write with program-enable set. Such an attempt sets status bit 2 (sequence error) and leaves the running operation's length unchanged. A control write with start set but sector-erase clear, or with a sector index of 12 or more, also sets bit 2 and starts nothing.
- R11: Status bit 1 (end of operation) sets when busy falls. Writing 1 to status bit 1 or bit 2 clears that bit. Writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 key, 1 control, 2 status |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| mem_wr | input | 1 | Byte write into the flash address space |
| mem_addr | input | 32 | Byte address |
| mem_wdata | input | 8 | Byte value |
| er_go | output | 1 | One-cycle erase command |
| er_bank | output | 1 | Bank of the erased sector |
| er_index | output | 4 | Sector index within the bank |
| er_base | output | 32 | Start address of the erased sector |
| er_size | output | 32 | Size of the erased sector in bytes |
| pg_go | output | 1 | One-cycle program command |
| pg_addr | output | 32 | Address being programmed |
| pg_data | output | 8 | Byte being programmed |
| busy | output | 1 | Operation in progress |

## Verification
The assertions check the following on every cycle:
- er_go and pg_go never pulse together.
- Every command strobe lands with busy set and while the key guard was open.
- No operation starts while one is running.
- Lock-out never clears.
- Each fall of busy leaves end-of-operation set and start cleared.

Only the bench scenarios show the register values read back, the exact busy lengths, the sector address arithmetic across both banks, and the handling of ignored writes and key ordering.

// File: rtl/flc_pkg.sv
package flc_pkg;
  localparam logic [1:0] A_KEY  = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  localparam int C_PG    = 0;
  localparam int C_SER   = 1;
  localparam int C_START = 2;
  localparam int C_SECT  = 4;   // 5-bit field, bit 4 of field = bank
  localparam int C_LOCK  = 31;

  localparam int S_BUSY = 0;
  localparam int S_EOP  = 1;
  localparam int S_SEQ  = 2;
  localparam int S_LOCK = 3;
  localparam int S_FAIL = 4;

  localparam logic [31:0] KEY_A = 32'h4567_0123;
  localparam logic [31:0] KEY_B = 32'hCDEF_89AB;

  typedef enum logic [1:0] {KG_IDLE, KG_HALF, KG_OPEN, KG_JAMMED} kg_state_e;

  function automatic logic [31:0] sect_offset(input logic [3:0] idx);
    if (idx <= 4'd4) return 32'(idx) * 32'h4000;
    return 32'h2_0000 + 32'(idx - 4'd5) * 32'h2_0000;
  endfunction

  function automatic logic [31:0] sect_size(input logic [3:0] idx);
    if (idx < 4'd4)  return 32'h4000;
    if (idx == 4'd4) return 32'h1_0000;
    return 32'h2_0000;
  endfunction
endpackage

// File: rtl/flc_key_guard.sv
module flc_key_guard
  import flc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr,
  input  logic [31:0] key_data,
  input  logic        relock,
  output logic        unlocked,
  output logic        keyfail
);
  kg_state_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= KG_IDLE;
    else begin
      case (st)
        KG_IDLE:  if (key_wr) st <= (key_data == KEY_A) ? KG_HALF : KG_JAMMED;
        KG_HALF:  if (key_wr) st <= (key_data == KEY_B) ? KG_OPEN : KG_JAMMED;
        KG_OPEN: begin
          if (key_wr)      st <= KG_JAMMED;
          else if (relock) st <= KG_IDLE;
        end
        default:  st <= KG_JAMMED;
      endcase
    end
  end

  assign unlocked = (st == KG_OPEN);
  assign keyfail  = (st == KG_JAMMED);

  AST_JAM_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    keyfail |=> (keyfail && !unlocked)); // R3
endmodule

// File: rtl/flc_op_timer.sv
module flc_op_timer #(
  parameter int ERASE_CYC = 40,
  parameter int PROG_CYC  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_er,
  input  logic start_pg,
  output logic busy,
  output logic done
);
  localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start_er) begin
      busy <= 1'b1;
      cnt  <= CW'(ERASE_CYC - 1);
    end else if (start_pg) begin
      busy <= 1'b1;
      cnt  <= CW'(PROG_CYC - 1);
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt  <= cnt - 1'b1;
    end
  end

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (start_er || start_pg) |-> !busy); // R10
endmodule

// File: rtl/flc_sector_map.sv
module flc_sector_map
  import flc_pkg::*;
#(
  parameter int          SECT_PER_BANK = 12,
  parameter logic [31:0] FLASH_BASE    = 32'h0800_0000
) (
  input  logic [4:0]  sect_field,
  output logic        valid,
  output logic        bank,
  output logic [3:0]  idx,
  output logic [31:0] base,
  output logic [31:0] size
);
  assign bank  = sect_field[4];
  assign idx   = sect_field[3:0];
  assign valid = (32'(idx) < 32'(SECT_PER_BANK));
  assign base  = FLASH_BASE + {11'd0, bank, 20'd0} + sect_offset(idx);
  assign size  = sect_size(idx);
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flc_pkg::*;
#(
  parameter int          ERASE_CYC     = 40,
  parameter int          PROG_CYC      = 6,
  parameter int          SECT_PER_BANK = 12,
  parameter logic [31:0] FLASH_BASE    = 32'h0800_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        mem_wr,
  input  logic [31:0] mem_addr,
  input  logic [7:0]  mem_wdata,
  output logic        er_go,
  output logic        er_bank,
  output logic [3:0]  er_index,
  output logic [31:0] er_base,
  output logic [31:0] er_size,
  output logic        pg_go,
  output logic [31:0] pg_addr,
  output logic [7:0]  pg_data,
  output logic        busy
);
  logic unlocked, keyfail, done;
  logic pg_q, ser_q, strt_q, eop_q, seq_q;
  logic [4:0] sect_q;
  logic m_valid, m_bank;
  logic [3:0] m_idx;
  logic [31:0] m_base, m_size;

  logic wr_key, wr_ctrl, wr_stat, ctrl_take, relock, start_req, start_er, start_pg, seq_set;
  logic unused_bits;
  assign unused_bits = ^{bus_wdata[30:9], bus_wdata[3]};

  assign wr_key    = bus_wr && (bus_addr == A_KEY);
  assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
  assign wr_stat   = bus_wr && (bus_addr == A_STAT);
  assign ctrl_take = wr_ctrl && unlocked && !busy && !bus_wdata[C_LOCK];
  assign relock    = wr_ctrl && unlocked && !busy &&  bus_wdata[C_LOCK];
  assign start_req = ctrl_take && bus_wdata[C_START];
  assign start_er  = start_req && bus_wdata[C_SER] && m_valid;
  assign start_pg  = mem_wr && pg_q && unlocked && !busy;
  assign seq_set   = (wr_ctrl && unlocked && busy && bus_wdata[C_START])
                   || (start_req && !start_er)
                   || (mem_wr && pg_q && unlocked && busy);

  flc_key_guard u_keys (
    .clk(clk), .rst_n(rst_n), .key_wr(wr_key), .key_data(bus_wdata),
    .relock(relock), .unlocked(unlocked), .keyfail(keyfail));

  flc_sector_map #(.SECT_PER_BANK(SECT_PER_BANK), .FLASH_BASE(FLASH_BASE)) u_map (
    .sect_field(bus_wdata[C_SECT +: 5]), .valid(m_valid), .bank(m_bank),
    .idx(m_idx), .base(m_base), .size(m_size));

  flc_op_timer #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_er(start_er), .start_pg(start_pg),
    .busy(busy), .done(done));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q <= 1'b0; ser_q <= 1'b0; strt_q <= 1'b0; sect_q <= '0;
      eop_q <= 1'b0; seq_q <= 1'b0;
      er_go <= 1'b0; er_bank <= 1'b0; er_index <= '0; er_base <= '0; er_size <= '0;
      pg_go <= 1'b0; pg_addr <= '0; pg_data <= '0;
    end else begin
      er_go <= start_er;
      pg_go <= start_pg;
      if (ctrl_take) begin
        pg_q   <= bus_wdata[C_PG];
        ser_q  <= bus_wdata[C_SER];
        sect_q <= bus_wdata[C_SECT +: 5];
        strt_q <= start_er;
      end else if (done) begin
        strt_q <= 1'b0;
      end
      if (start_er) begin
        er_bank <= m_bank; er_index <= m_idx; er_base <= m_base; er_size <= m_size;
      end
      if (start_pg) begin
        pg_addr <= mem_addr; pg_data <= mem_wdata;
      end
      if (done) eop_q <= 1'b1;
      else if (wr_stat && bus_wdata[S_EOP]) eop_q <= 1'b0;
      if (seq_set) seq_q <= 1'b1;
      else if (wr_stat && bus_wdata[S_SEQ]) seq_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[C_LOCK]      = !unlocked;
        bus_rdata[C_SECT +: 5] = sect_q;
        bus_rdata[C_START]     = strt_q;
        bus_rdata[C_SER]       = ser_q;
        bus_rdata[C_PG]        = pg_q;
      end
      A_STAT: begin
        bus_rdata[S_BUSY] = busy;
        bus_rdata[S_EOP]  = eop_q;
        bus_rdata[S_SEQ]  = seq_q;
        bus_rdata[S_LOCK] = !unlocked;
        bus_rdata[S_FAIL] = keyfail;
      end
      default: bus_rdata = '0;
    endcase
  end

  AST_GO_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(er_go && pg_go)); // R8
  AST_ERASE_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (er_go || pg_go) |-> busy); // R7
  AST_GO_NEEDS_KEYS: assert property (@(posedge clk) disable iff (!rst_n)
    (er_go || pg_go) |-> $past(unlocked)); // R4
  AST_EOP_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (eop_q && !strt_q)); // R11
  AST_ERASE_SECT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    er_go |-> (32'(er_index) < 32'(SECT_PER_BANK))); // R6
endmodule

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
  localparam int ERASE_CYC = 40;
  localparam int PROG_CYC  = 6;
  localparam logic [31:0] FBASE = 32'h0800_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, mem_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, mem_addr = '0, bus_rdata, er_base, er_size, pg_addr;
  logic [7:0] mem_wdata = '0, pg_data;
  logic er_go, er_bank, pg_go, busy;
  logic [3:0] er_index;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  flash_cmd_ctrl #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC), .FLASH_BASE(FBASE)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .er_go(er_go), .er_bank(er_bank), .er_index(er_index), .er_base(er_base), .er_size(er_size),
    .pg_go(pg_go), .pg_addr(pg_addr), .pg_data(pg_data), .busy(busy));

  function automatic logic [31:0] exp_base(input int bank, input int idx);
    int off = 0;
    for (int k = 0; k < idx; k++) off += (k < 4) ? 16384 : (k == 4) ? 65536 : 131072;
    return FBASE + 32'(bank) * 32'h10_0000 + 32'(off);
  endfunction
  function automatic logic [31:0] exp_size(input int idx);
    return (idx < 4) ? 32'h4000 : (idx == 4) ? 32'h1_0000 : 32'h2_0000;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask
  task automatic mw(input logic [31:0] a, input logic [7:0] d);
    @(negedge clk); mem_wr = 1'b1; mem_addr = a; mem_wdata = d;
    @(negedge clk); mem_wr = 1'b0;
  endtask
  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask
  task automatic wait_idle(output int n);
    n = 0;
    while (busy === 1'b1 && n < 1000) begin n++; @(negedge clk); end
  endtask
  task automatic unlock();
    wr(2'd0, 32'h4567_0123); wr(2'd0, 32'hCDEF_89AB);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd1, d); chk("R1 ctrl", d, 32'h8000_0000);
    rd(2'd2, d); chk("R1 stat", d, 32'h0000_0008);
    chk("R1 busy", {31'd0, busy}, 0);
    // R4 locked control write ignored
    wr(2'd1, 32'h0000_0026);
    chk("R4 no er_go", {31'd0, er_go}, 0);
    chk("R4 no busy", {31'd0, busy}, 0);
    rd(2'd1, d); chk("R4 ctrl unchanged", d, 32'h8000_0000);
    // R2 unlock
    unlock();
    rd(2'd2, d); chk("R2 stat unlocked", d, 0);
    rd(2'd1, d); chk("R2 ctrl unlocked", d, 0);
    // R6 setup without start does nothing
    wr(2'd1, 32'h0000_01B2);
    chk("R6 no start without STRT", {31'd0, er_go}, 0);
    // R6/R7 directed erase: bank1 sector 11
    wr(2'd1, 32'h0000_01B6);
    chk("R6 er_go", {31'd0, er_go}, 1);
    chk("R6 bank", {31'd0, er_bank}, 1);
    chk("R6 index", {28'd0, er_index}, 11);
    chk("R6 base", er_base, exp_base(1, 11));
    chk("R6 size", er_size, exp_size(11));
    rd(2'd1, d); chk("R7 start during op", d & 32'h4, 32'h4);
    wait_idle(n);
    chk("R7 erase busy length", 32'(n), ERASE_CYC);
    rd(2'd1, d); chk("R7 start cleared, ser kept", d, 32'h0000_01B2);
    rd(2'd2, d); chk("R11 eop set", d, 32'h2);
    wr(2'd2, 32'h0);
    rd(2'd2, d); chk("R11 write 0 keeps eop", d, 32'h2);
    wr(2'd2, 32'h2);
    rd(2'd2, d); chk("R11 w1c eop", d, 0);
    // R10 start while busy
    wr(2'd1, 32'h0000_0036);
    wr(2'd1, 32'h0000_0046);
    chk("R10 no second er_go", {31'd0, er_go}, 0);
    rd(2'd2, d); chk("R10 seq err", d & 32'h4, 32'h4);
    wait_idle(n);
    chk("R10 length unchanged", 32'(n), ERASE_CYC - 2);
    rd(2'd1, d); chk("R10 ctrl kept first sector", d, 32'h0000_0032);
    wr(2'd2, 32'h6);
    rd(2'd2, d); chk("R11 w1c seq", d, 0);
    // R10 invalid sector / ser clear
    wr(2'd1, 32'h0000_00C6);
    chk("R10 invalid sector no go", {31'd0, er_go | busy}, 0);
    rd(2'd2, d); chk("R10 invalid sector seq", d, 32'h4);
    wr(2'd2, 32'h4);
    wr(2'd1, 32'h0000_0014);
    chk("R10 ser clear no go", {31'd0, er_go | busy}, 0);
    rd(2'd2, d); chk("R10 ser clear seq", d, 32'h4);
    wr(2'd2, 32'h4);
    // R6 random erases
    for (int i = 0; i < 20; i++) begin
      int b = $urandom_range(0, 1);
      int x = $urandom_range(0, 11);
      wr(2'd1, 32'h6 | (32'(b) << 8) | (32'(x) << 4));
      chk("R6 rand go", {31'd0, er_go}, 1);
      chk("R6 rand bank", {31'd0, er_bank}, 32'(b));
      chk("R6 rand idx", {28'd0, er_index}, 32'(x));
      chk("R6 rand base", er_base, exp_base(b, x));
      chk("R6 rand size", er_size, exp_size(x));
      wait_idle(n);
      chk("R7 rand erase len", 32'(n), ERASE_CYC);
    end
    // R9 program with PG clear
    wr(2'd1, 32'h0);
    mw(32'h0800_0010, 8'h5A);
    chk("R9 pg clear no go", {31'd0, pg_go | busy}, 0);
    // R8 programs
    wr(2'd1, 32'h1);
    for (int i = 0; i < 20; i++) begin
      logic [31:0] a = FBASE + ($urandom & 32'h1F_FFFF);
      logic [7:0] v = 8'($urandom);
      mw(a, v);
      chk("R8 pg_go", {31'd0, pg_go}, 1);
      chk("R8 pg_addr", pg_addr, a);
      chk("R8 pg_data", {24'd0, pg_data}, {24'd0, v});
      wait_idle(n);
      chk("R7 prog len", 32'(n), PROG_CYC);
    end
    rd(2'd1, d); chk("R7 pg kept", d, 32'h1);
    // R10 program while busy
    wr(2'd2, 32'h6);
    mw(FBASE, 8'h11);
    mw(FBASE + 1, 8'h22);
    chk("R10 no second pg_go", {31'd0, pg_go}, 0);
    chk("R10 pg_addr kept", pg_addr, FBASE);
    rd(2'd2, d); chk("R10 prog seq", d & 32'h4, 32'h4);
    wait_idle(n);
    wr(2'd2, 32'h6);
    // R5 relock
    wr(2'd1, 32'h8000_0000);
    rd(2'd2, d); chk("R5 locked", d, 32'h8);
    rd(2'd1, d); chk("R5 fields kept", d, 32'h8000_0001);
    mw(FBASE + 4, 8'h33);
    chk("R9 locked no pg_go", {31'd0, pg_go | busy}, 0);
    wr(2'd1, 32'h0);
    rd(2'd1, d); chk("R5 ctrl ignored while relocked", d, 32'h8000_0001);
    unlock();
    rd(2'd2, d); chk("R5 fresh keys reopen", d, 0);
    // R3 key write while unlocked
    wr(2'd0, 32'h4567_0123);
    rd(2'd2, d); chk("R3 lockout", d, 32'h18);
    unlock();
    rd(2'd2, d); chk("R3 stays locked", d, 32'h18);
    wr(2'd1, 32'h0);
    rd(2'd1, d); chk("R3 ctrl ignored", d, 32'h8000_0001);
    // R2/R3 wrong second key after reset
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    wr(2'd0, 32'h4567_0123); wr(2'd0, 32'h4567_0123);
    rd(2'd2, d); chk("R2 wrong second key", d, 32'h18);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    wr(2'd0, 32'hCDEF_89AB);
    rd(2'd2, d); chk("R3 wrong first key", d, 32'h18);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule